// File: doc/BRIEF.md
# Memory-Range CRC32 Scan Engine

This block computes a 32-bit cyclic redundancy check over a contiguous, word-aligned region of memory without processor involvement. Software programs a start address, a byte count and a seed value, then sets a start bit. The engine acts as a bus master: it issues one 32-bit read at a time on a simple request/response port and folds the four bytes of each returned word into a reflected CRC, one byte per clock. When the walk ends, a done flag rises. The raw CRC is then readable from the data register, and a separate flag tells whether any read came back with an error.

The result is left without a final inversion. Software complements it to obtain the conventional CRC32, or writes it back as the seed of a further scan so that several disjoint regions yield one combined checksum. A protected mode, controlled by an input pin, ignores the software-written address, length and seed. Instead it takes fixed region bounds chosen by a two-bit area selector and a seed of all ones. This lets the contents of a locked device be checked without exposing them.

Top module: `crc_scan_engine`

## Requirements
- R1: The CRC uses the reflected polynomial 0xEDB88320, processed LSB-first. The bytes of each fetched word are folded in little-endian order (bits 7:0 first), one byte per clock. No final inversion is applied, and the running value is readable in the data register.
- R2: Register select values are as follows. Select 0 is the address, 1 the length in bytes, 2 the data (seed in, result out), 3 the control and 4 the status. Before a start, software writes the seed into the data register. Loading a previous result as the seed extends the CRC across a further region.
- R3: A control write with bit 1 set and bit 0 clear starts a scan and clears both flags. Status bit 0 (done) is set when the scan ends. Status bit 1 (error) is then 1 only if a fetch failed.
- R4: The low two bits of the address and length registers are disregarded. Words are fetched at ascending word-aligned addresses. A request is held, with a stable address, until its response arrives.
- R5: A length below 4 completes with done set, no fetch and the data register unchanged.
- R6: A fetch returning an error ends the scan at that word, which is not folded in. Done and error are both set, no further request is made, and the data register holds the CRC of the words before the faulting one.
- R7: With the protect input high, a start uses fixed values. Area 0 selects the main-array base and size, area 1 selects the emulated-EEPROM base and size, and the seed is 0xFFFFFFFF. The address, length and data registers read back these forced values at the start.
- R8: With the protect input high and area select 2 or 3, a start sets done and error on the next clock edge and fetches nothing.
- R9: While a scan runs, writes to the address, length and data registers and further start commands are ignored.
- R10: A control write with bit 0 set aborts any scan. It clears the address, length and data registers and both flags, and drops the memory request.
- R11: After reset all registers read zero and no memory request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| prot_en | input | 1 | Protected mode enable |
| area_sel | input | 2 | Protected area selector |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response data |
| mem_rerr | input | 1 | Memory response error |

## Verification
The hardest situation to reach from the ports is a fetch error in the middle of a region. It has to abort the walk after exactly the preceding words have been folded, leaving a partial CRC in the data register. The bench memory model flags a chosen word address as faulty. It then compares the data register with a CRC computed over only the bytes below that address, and counts the requests actually granted. A second hard case is a write arriving while the engine is busy. The bench issues it a few cycles after a start and shows that the final result and the address readback are untouched.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NEXT  = 2'd1,
    ST_FETCH = 2'd2,
    ST_FOLD  = 2'd3
  } scan_state_e;

  localparam logic [2:0] SEL_ADDR = 3'd0;
  localparam logic [2:0] SEL_LEN  = 3'd1;
  localparam logic [2:0] SEL_DATA = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  localparam int CTRL_SRST_BIT  = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int STAT_DONE_BIT  = 0;
  localparam int STAT_BERR_BIT  = 1;
endpackage

// File: rtl/crc_scan_step.sv
module crc_scan_step #(
  parameter logic [31:0] POLY = crc_scan_pkg::CRC_POLY
) (
  input  logic [31:0] crc_in,
  input  logic [7:0]  data_in,
  output logic [31:0] crc_out
);
  logic [31:0] stage [0:8];

  assign stage[0] = crc_in ^ {24'h0, data_in};

  // one reflected shift per bit, LSB first
  generate
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign stage[k+1] = stage[k][0] ? ({1'b0, stage[k][31:1]} ^ POLY)
                                      : {1'b0, stage[k][31:1]};
    end
  endgenerate

  assign crc_out = stage[8];
endmodule

// File: rtl/crc_scan_regs.sv
module crc_scan_regs
  import crc_scan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              start_ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_seed_en,
  input  logic [31:0]       ld_seed,
  input  logic              byte_ld,
  input  logic [31:0]       crc_nxt,
  input  logic              fin,
  input  logic              fin_err,
  output logic              start_req,
  output logic              srst_req,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [31:0]       data_q,
  output logic              done_q,
  output logic              berr_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [LEN_W-1:0]  len_d;
  logic [31:0]       data_d;
  logic              done_d, berr_d;
  logic              ctrl_wr;

  assign ctrl_wr   = wr_en && (sel == SEL_CTRL);
  assign srst_req  = ctrl_wr && wdata[CTRL_SRST_BIT];
  assign start_req = ctrl_wr && wdata[CTRL_START_BIT] && !wdata[CTRL_SRST_BIT];

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    data_d = data_q;
    done_d = done_q;
    berr_d = berr_q;
    if (srst_req) begin
      addr_d = '0;
      len_d  = '0;
      data_d = '0;
      done_d = 1'b0;
      berr_d = 1'b0;
    end else begin
      if (wr_en && !busy) begin
        if (sel == SEL_ADDR) addr_d = wdata[ADDR_W-1:0];
        if (sel == SEL_LEN)  len_d  = wdata[LEN_W-1:0];
        if (sel == SEL_DATA) data_d = wdata;
      end
      if (start_ld) begin
        addr_d = ld_addr;
        len_d  = ld_len;
        if (ld_seed_en) data_d = ld_seed;
        done_d = 1'b0;
        berr_d = 1'b0;
      end
      if (byte_ld) data_d = crc_nxt;
      if (fin) begin
        done_d = 1'b1;
        berr_d = fin_err;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
      data_q <= data_d;
      done_q <= done_d;
      berr_q <= berr_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_ADDR: rdata = 32'(addr_q);
      SEL_LEN:  rdata = 32'(len_q);
      SEL_DATA: rdata = data_q;
      SEL_STAT: begin
        rdata[STAT_DONE_BIT] = done_q;
        rdata[STAT_BERR_BIT] = berr_q;
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl
  import crc_scan_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          LEN_W       = 16,
  parameter logic [31:0] ARRAY_BASE  = 32'h0000_0000,
  parameter logic [31:0] ARRAY_BYTES = 32'h0000_C000,
  parameter logic [31:0] EE_BASE     = 32'h0000_C000,
  parameter logic [31:0] EE_BYTES    = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              srst_req,
  input  logic              prot_en,
  input  logic [1:0]        area_sel,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LEN_W-1:0]  len_q,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rerr,
  output logic              start_ld,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [LEN_W-1:0]  ld_len,
  output logic              ld_seed_en,
  output logic [31:0]       ld_seed,
  output logic              byte_ld,
  output logic [7:0]        fold_byte,
  output logic              fin,
  output logic              fin_err
);
  localparam int WA_W = ADDR_W - 2;
  localparam int WC_W = LEN_W - 2;

  scan_state_e      state_q, state_d;
  logic [WA_W-1:0]  waddr_q, waddr_d;
  logic [WC_W-1:0]  words_q, words_d;
  logic [31:0]      word_q, word_d;
  logic [1:0]       bidx_q, bidx_d;
  logic             reserved_area;
  logic             unused_low;

  // effective region and seed, forced in protected mode
  always_comb begin
    ld_addr    = addr_q;
    ld_len     = len_q;
    ld_seed_en = 1'b0;
    if (prot_en) begin
      ld_seed_en = 1'b1;
      if (area_sel[0]) begin
        ld_addr = ADDR_W'(EE_BASE);
        ld_len  = LEN_W'(EE_BYTES);
      end else begin
        ld_addr = ADDR_W'(ARRAY_BASE);
        ld_len  = LEN_W'(ARRAY_BYTES);
      end
    end
  end

  assign ld_seed       = 32'hFFFF_FFFF;
  assign reserved_area = prot_en && area_sel[1];
  assign unused_low    = ^{ld_addr[1:0], ld_len[1:0]};

  always_comb begin
    state_d  = state_q;
    waddr_d  = waddr_q;
    words_d  = words_q;
    word_d   = word_q;
    bidx_d   = bidx_q;
    start_ld = 1'b0;
    byte_ld  = 1'b0;
    fin      = 1'b0;
    fin_err  = 1'b0;
    mem_req  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          if (reserved_area) begin
            fin     = 1'b1;
            fin_err = 1'b1;
          end else begin
            start_ld = 1'b1;
            waddr_d  = ld_addr[ADDR_W-1:2];
            words_d  = ld_len[LEN_W-1:2];
            state_d  = ST_NEXT;
          end
        end
      end
      ST_NEXT: begin
        if (words_q == '0) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_rvalid) begin
          if (mem_rerr) begin
            fin     = 1'b1;
            fin_err = 1'b1;
            state_d = ST_IDLE;
          end else begin
            word_d  = mem_rdata;
            bidx_d  = 2'd0;
            state_d = ST_FOLD;
          end
        end
      end
      ST_FOLD: begin
        byte_ld = 1'b1;
        bidx_d  = bidx_q + 2'd1;
        if (bidx_q == 2'd3) begin
          waddr_d = waddr_q + 1'b1;
          words_d = words_q - 1'b1;
          state_d = ST_NEXT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (srst_req) begin
      state_d  = ST_IDLE;
      start_ld = 1'b0;
      byte_ld  = 1'b0;
      fin      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      waddr_q <= '0;
      words_q <= '0;
      word_q  <= '0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      waddr_q <= waddr_d;
      words_q <= words_d;
      word_q  <= word_d;
      bidx_q  <= bidx_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_addr  = {waddr_q, 2'b00};
  assign fold_byte = word_q[8*bidx_q +: 8];
endmodule

// File: rtl/crc_scan_engine.sv
module crc_scan_engine #(
  parameter int          ADDR_W      = 32,
  parameter int          LEN_W       = 16,
  parameter logic [31:0] ARRAY_BASE  = 32'h0000_0000,
  parameter logic [31:0] ARRAY_BYTES = 32'h0000_C000,
  parameter logic [31:0] EE_BASE     = 32'h0000_C000,
  parameter logic [31:0] EE_BYTES    = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              prot_en,
  input  logic [1:0]        area_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rerr
);
  logic              busy, start_req, srst_req, start_ld, ld_seed_en;
  logic              byte_ld, fin, fin_err, done_q, berr_q;
  logic [ADDR_W-1:0] addr_q, ld_addr;
  logic [LEN_W-1:0]  len_q, ld_len;
  logic [31:0]       data_q, ld_seed, crc_nxt;
  logic [7:0]        fold_byte;

  crc_scan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
    .start_ld(start_ld), .ld_addr(ld_addr), .ld_len(ld_len),
    .ld_seed_en(ld_seed_en), .ld_seed(ld_seed), .byte_ld(byte_ld),
    .crc_nxt(crc_nxt), .fin(fin), .fin_err(fin_err),
    .start_req(start_req), .srst_req(srst_req), .addr_q(addr_q),
    .len_q(len_q), .data_q(data_q), .done_q(done_q), .berr_q(berr_q)
  );

  crc_scan_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .ARRAY_BASE(ARRAY_BASE), .ARRAY_BYTES(ARRAY_BYTES),
    .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .srst_req(srst_req),
    .prot_en(prot_en), .area_sel(area_sel), .addr_q(addr_q), .len_q(len_q),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .start_ld(start_ld), .ld_addr(ld_addr), .ld_len(ld_len),
    .ld_seed_en(ld_seed_en), .ld_seed(ld_seed), .byte_ld(byte_ld),
    .fold_byte(fold_byte), .fin(fin), .fin_err(fin_err)
  );

  crc_scan_step u_step (
    .crc_in(data_q), .data_in(fold_byte), .crc_out(crc_nxt)
  );
endmodule

// File: rtl/crc_scan_engine_chk.sv
module crc_scan_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [31:0]       reg_wdata,
  input logic              prot_en,
  input logic [1:0]        area_sel,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              mem_rerr,
  input logic              busy,
  input logic              done_q,
  input logic              berr_q,
  input logic [ADDR_W-1:0] addr_q
);
  logic srst_wr, start_wr;
  assign srst_wr  = reg_wr && (reg_sel == 3'd3) && reg_wdata[0];
  assign start_wr = reg_wr && (reg_sel == 3'd3) && reg_wdata[1] && !reg_wdata[0];

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !srst_wr) |=> (mem_req && $stable(mem_addr)));

  // R4
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R6
  berr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && mem_rerr && !srst_wr) |=> (!mem_req && done_q && berr_q));

  // R8
  reserved_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !busy && prot_en && area_sel[1]) |=> (done_q && berr_q && !busy));

  // R9
  busy_addr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_sel == 3'd0)) |=> $stable(addr_q));

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (!busy && !done_q && !berr_q && !mem_req));
endmodule

bind crc_scan_engine crc_scan_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .prot_en(prot_en), .area_sel(area_sel),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .mem_rerr(mem_rerr), .busy(busy), .done_q(done_q), .berr_q(berr_q),
  .addr_q(addr_q)
);

// File: tb/crc_scan_engine_bench.sv
module crc_scan_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam logic [31:0] A_BASE  = 32'h0;
  localparam logic [31:0] A_BYTES = 32'd128;
  localparam logic [31:0] E_BASE  = 32'h80;
  localparam logic [31:0] E_BYTES = 32'd32;

  logic        clk, rst_n, reg_wr, prot_en, mem_req, mem_rvalid, mem_rerr;
  logic [2:0]  reg_sel;
  logic [1:0]  area_sel;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_rdata;
  logic [31:0] mem [0:MEM_WORDS-1];
  logic        err_en;
  logic [31:0] err_addr;
  int          n_tests, n_fail, fetches;
  bit          finished;

  crc_scan_engine #(
    .ADDR_W(32), .LEN_W(16),
    .ARRAY_BASE(A_BASE), .ARRAY_BYTES(A_BYTES),
    .EE_BASE(E_BASE), .EE_BYTES(E_BYTES)
  ) u_crc_scan_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_en(prot_en),
    .area_sel(area_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // memory model: one-cycle response, errors on a chosen word or out of range
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      mem_rerr   <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 1'b0;
      if (mem_req && !mem_rvalid) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[(mem_addr >> 2) % MEM_WORDS];
        mem_rerr   <= (err_en && mem_addr == err_addr) ||
                      (mem_addr >= 32'(MEM_WORDS * 4));
      end
    end
  end

  always @(posedge clk) if (mem_req && mem_rvalid) fetches++;

  function automatic logic [31:0] crc_ref(logic [31:0] seed, logic [31:0] base,
                                          int nbytes);
    logic [31:0] c = seed;
    for (int b = 0; b < nbytes; b++) begin
      logic [31:0] a = base + 32'(b);
      logic [31:0] w = mem[(a >> 2) % MEM_WORDS];
      c = c ^ {24'h0, w[8*a[1:0] +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] sel, logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    for (int i = 0; i < 3000; i++) begin
      reg_read(3'd4, st);
      if (st[0]) return;
    end
  endtask

  task automatic run_scan(logic [31:0] a, logic [31:0] l, logic [31:0] s);
    reg_write(3'd0, a);
    reg_write(3'd1, l);
    reg_write(3'd2, s);
    fetches = 0;
    reg_write(3'd3, 32'h2);
    wait_done();
  endtask

  // table: address, length, seed
  localparam int NV = 5;
  localparam logic [95:0] VEC [NV] = '{
    {32'h0000_0000, 32'd16, 32'hFFFF_FFFF},
    {32'h0000_0004, 32'd32, 32'h0000_0000},
    {32'h0000_0040, 32'd4,  32'h1234_5678},
    {32'h0000_0021, 32'd11, 32'hFFFF_FFFF},
    {32'h0000_0080, 32'd64, 32'hA5A5_0F0F}
  };

  initial begin
    logic [31:0] rd, r1, exp;
    n_tests = 0; n_fail = 0; fetches = 0; finished = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    prot_en = 1'b0; area_sel = '0; err_en = 1'b0; err_addr = '0;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h0123_4567;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int s = 0; s < 5; s++) begin
      reg_read(3'(s), rd);
      check(rd == 0, "R11 reset register", rd, 0);
    end
    check(mem_req == 1'b0, "R11 reset mem_req", 32'(mem_req), 0);

    // R1 R3 R4 table of scans
    for (int v = 0; v < NV; v++) begin
      logic [31:0] va = VEC[v][95:64], vl = VEC[v][63:32], vs = VEC[v][31:0];
      run_scan(va, vl, vs);
      exp = crc_ref(vs, va & ~32'h3, int'(vl & ~32'h3));
      reg_read(3'd2, rd);
      check(rd == exp, "R1 table crc", rd, exp);
      reg_read(3'd4, rd);
      check(rd == 32'h1, "R3 table status", rd, 32'h1);
      check(fetches == int'(vl >> 2), "R4 table fetch count", 32'(fetches), vl >> 2);
    end

    // R2 chaining two regions equals one region
    run_scan(32'h0, 32'd16, 32'hFFFF_FFFF);
    reg_read(3'd2, r1);
    run_scan(32'h10, 32'd16, r1);
    reg_read(3'd2, rd);
    exp = crc_ref(32'hFFFF_FFFF, 32'h0, 32);
    check(rd == exp, "R2 chained crc", rd, exp);

    // R5 zero and sub-word length
    run_scan(32'h8, 32'd3, 32'hCAFE_F00D);
    reg_read(3'd2, rd);
    check(rd == 32'hCAFE_F00D, "R5 short length seed kept", rd, 32'hCAFE_F00D);
    check(fetches == 0, "R5 short length no fetch", 32'(fetches), 0);
    reg_read(3'd4, rd);
    check(rd == 32'h1, "R5 short length done", rd, 32'h1);

    // R6 bus error on the fourth word
    err_en = 1'b1; err_addr = 32'h0C;
    run_scan(32'h0, 32'd32, 32'hFFFF_FFFF);
    reg_read(3'd2, rd);
    exp = crc_ref(32'hFFFF_FFFF, 32'h0, 12);
    check(rd == exp, "R6 partial crc", rd, exp);
    reg_read(3'd4, rd);
    check(rd == 32'h3, "R6 status done+err", rd, 32'h3);
    check(fetches == 4, "R6 fetch count", 32'(fetches), 4);
    err_en = 1'b0;
    // R3 next start clears error flag
    run_scan(32'h0, 32'd8, 32'hFFFF_FFFF);
    reg_read(3'd4, rd);
    check(rd == 32'h1, "R3 flags cleared by start", rd, 32'h1);

    // R7 protected areas
    for (int a = 0; a < 2; a++) begin
      prot_en = 1'b1; area_sel = 2'(a);
      run_scan(32'h44, 32'd8, 32'h0);
      exp = (a == 0) ? crc_ref(32'hFFFF_FFFF, A_BASE, int'(A_BYTES))
                     : crc_ref(32'hFFFF_FFFF, E_BASE, int'(E_BYTES));
      reg_read(3'd2, rd);
      check(rd == exp, "R7 protected crc", rd, exp);
      reg_read(3'd0, rd);
      exp = (a == 0) ? A_BASE : E_BASE;
      check(rd == exp, "R7 forced address", rd, exp);
      reg_read(3'd1, rd);
      exp = (a == 0) ? A_BYTES : E_BYTES;
      check(rd == exp, "R7 forced length", rd, exp);
      prot_en = 1'b0;
    end

    // R8 reserved areas
    for (int a = 2; a < 4; a++) begin
      prot_en = 1'b1; area_sel = 2'(a);
      run_scan(32'h0, 32'd0, 32'h0);
      fetches = 0;
      reg_write(3'd3, 32'h2);
      reg_read(3'd4, rd);
      check(rd == 32'h3, "R8 reserved done+err next cycle", rd, 32'h3);
      repeat (10) @(negedge clk);
      check(fetches == 0, "R8 reserved no fetch", 32'(fetches), 0);
      prot_en = 1'b0;
    end
    area_sel = 2'd0;

    // R9 writes while busy ignored
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'd64);
    reg_write(3'd2, 32'hFFFF_FFFF);
    fetches = 0;
    reg_write(3'd3, 32'h2);
    repeat (3) @(negedge clk);
    reg_write(3'd0, 32'h44);
    reg_write(3'd1, 32'd4);
    reg_write(3'd2, 32'h0);
    reg_write(3'd3, 32'h2);
    wait_done();
    reg_read(3'd2, rd);
    exp = crc_ref(32'hFFFF_FFFF, 32'h0, 64);
    check(rd == exp, "R9 busy writes ignored crc", rd, exp);
    reg_read(3'd0, rd);
    check(rd == 32'h0, "R9 busy address kept", rd, 32'h0);
    check(fetches == 16, "R9 fetch count", 32'(fetches), 16);

    // R10 soft reset aborts
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'd128);
    reg_write(3'd2, 32'hFFFF_FFFF);
    reg_write(3'd3, 32'h2);
    repeat (6) @(negedge clk);
    reg_write(3'd3, 32'h1);
    fetches = 0;
    repeat (10) @(negedge clk);
    check(fetches == 0, "R10 no fetch after abort", 32'(fetches), 0);
    check(mem_req == 1'b0, "R10 request dropped", 32'(mem_req), 0);
    for (int s = 0; s < 5; s++) begin
      reg_read(3'(s), rd);
      check(rd == 0, "R10 registers cleared", rd, 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule